// File: doc/BRIEF.md
# Auto-Increment Buffer Pointer Port

This block gives a host byte-level access to a small paged packet memory through a 16-bit pointer register and a four-byte data window. The pointer's low eleven bits are a byte offset inside a 2048-byte page. Its top bit chooses the page: either the page at the head of the receive queue or the page the host has placed in the packet-number register. Both page numbers arrive as inputs from neighbouring logic. The next bit down chooses how the pointer behaves. In one mode it steps by one after every data byte, wrapping inside the page. In the other it stays fixed, and the window byte index is added to it.

A host access is either a single byte or, for the window only, a 32-bit word. A word access is split into four byte beats in ascending byte order, and each beat applies the pointer rule in turn. The page store is a synchronous RAM. Read data returns one cycle after the last beat, marked by a one-cycle valid pulse. While a word access is in progress the port reports not-ready.

Top module: `bufptr_port`

## Requirements
- R1: After reset the pointer reads as zero in both bytes, `host_ready` is 1 and `host_rvalid` is 0.
- R2: A byte write to host address 0 loads pointer bits 7:0, and a byte write to address 1 loads bits 15:8. A byte read of address 0 returns bits 7:0 in `host_rdata[7:0]`.
- R3: A byte read of host address 1 returns pointer bits 15:8 with bit 3 of the returned byte (pointer bit 11) forced to 0, so the byte is ANDed with 0xF7.
- R4: When pointer bit 15 is 1, window accesses target page `rx_head`. When it is 0, they target page `pkt_page`.
- R5: When pointer bit 14 is 0, a window byte at host address 4+k (k = 0..3) targets offset (pointer[10:0] + k) mod 2048, and the pointer keeps its value.
- R6: When pointer bit 14 is 1, every window byte targets offset pointer[10:0], ignoring k. Afterwards pointer[10:0] becomes (pointer[10:0] + 1) mod 2048 and bits 15:11 are kept.
- R7: A word access (`host_word` = 1) to any window address runs four byte beats, k = 0 to 3 in order. Byte k maps to data bits 8k+7:8k, and `host_ready` is 0 for the three cycles after acceptance. For pointer addresses `host_word` is ignored and a single byte is accessed.
- R8: For a read, `host_rvalid` is 1 for exactly one cycle: the cycle after the final beat, which is 1 cycle after acceptance for a byte and 4 cycles after for a word. A write never raises `host_rvalid`.
- R9: A request presented while `host_ready` is 0 is not accepted and has no effect.
- R10: A write to one page leaves the same offset of every other page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, taken when `host_ready` is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = 32-bit window access |
| host_addr | input | 3 | 0 pointer low, 1 pointer high, 4..7 window byte 0..3 |
| host_wdata | input | 32 | Write data; byte accesses use bits 7:0 |
| host_ready | output | 1 | Port idle, can take a request |
| host_rdata | output | 32 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | One-cycle read-return pulse |
| pkt_page | input | PAGE_W | Page chosen by the host packet-number register |
| rx_head | input | PAGE_W | Page at the head of the receive queue |

## Verification
The bench builds the block with the default of four pages, so the page inputs are two bits wide and all four pages can be reached and checked against each other for isolation. The offset keeps its full eleven bits, and the wrap at offset 0x7FF is reached by loading the pointer just below it. The bench covers both the stepping rule and the index-sum rule across that wrap. It also checks four-beat word packing in both pointer modes and a request held while the port is busy.

// File: rtl/bufptr_pkg.sv
// Package: shared constants and types for the buffer pointer port.
// Assumes a 16-bit pointer made of two host bytes and a four-byte window.
package bufptr_pkg;
    localparam int PTR_W   = 16;
    localparam int OFF_W   = 11;
    localparam int LANES   = 4;
    localparam int LANE_W  = $clog2(LANES);
    localparam int SEL_BIT = PTR_W - 1;   // page source select
    localparam int INC_BIT = PTR_W - 2;   // auto-step select
    localparam logic [7:0] HI_MASK = 8'hF7;

    typedef enum logic [1:0] {
        SRC_PTR  = 2'd0,
        SRC_BYTE = 2'd1,
        SRC_WORD = 2'd2
    } rsrc_e;
endpackage

// File: rtl/bufptr_reg.sv
// Pointer register: byte-loadable 16-bit pointer with an in-page step.
// Assumes a load and a step never happen in the same cycle.
module bufptr_reg
    import bufptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       ld_byte,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [OFF_W-1:0] OFF_ONE = 1;

    // Load bytes from the host or step the offset field with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[7:0] <= ld_byte;
        end else if (ld_hi) begin
            ptr[PTR_W-1:8] <= ld_byte;
        end else if (step) begin
            ptr[OFF_W-1:0] <= ptr[OFF_W-1:0] + OFF_ONE;
        end
    end
endmodule

// File: rtl/bufptr_seq.sv
// Beat sequencer: turns one host request into byte beats for the window.
// A word access to the window yields lanes 0..3 over four cycles. Any other
// request yields at most one beat in the cycle it is taken.
module bufptr_seq
    import bufptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_word,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic              beat_v,
    output logic              beat_wr,
    output logic [LANE_W-1:0] beat_lane,
    output logic [7:0]        beat_byte,
    output logic              beat_last,
    output logic              beat_word,
    output logic              ptr_acc
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
    localparam logic [LANE_W-1:0] LANE_ONE  = 1;

    logic                        busy_q;
    logic [LANE_W-1:0]           lane_q;
    logic                        wr_q;
    logic [LANES-1:0][7:0]       wd_q;
    logic                        accept;
    logic                        win;

    assign host_ready = !busy_q;
    assign accept     = host_req && !busy_q;
    assign win        = host_addr[2];
    assign beat_word  = busy_q;
    assign ptr_acc    = accept && !win;

    // Present the current beat: a held word beat, or the new request.
    always_comb begin
        beat_v    = 1'b0;
        beat_wr   = 1'b0;
        beat_lane = '0;
        beat_byte = '0;
        beat_last = 1'b0;
        if (busy_q) begin
            beat_v    = 1'b1;
            beat_wr   = wr_q;
            beat_lane = lane_q;
            beat_byte = wd_q[lane_q];
            beat_last = (lane_q == LAST_LANE);
        end else if (accept && win) begin
            beat_v    = 1'b1;
            beat_wr   = host_wr;
            beat_lane = host_word ? '0 : host_addr[LANE_W-1:0];
            beat_byte = host_wdata[7:0];
            beat_last = !host_word;
        end
    end

    // Hold a word access and walk its remaining lanes in ascending order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lane_q <= '0;
            wr_q   <= 1'b0;
            wd_q   <= '0;
        end else if (busy_q) begin
            if (lane_q == LAST_LANE) begin
                busy_q <= 1'b0;
            end
            lane_q <= lane_q + LANE_ONE;
        end else if (accept && win && host_word) begin
            busy_q <= 1'b1;
            lane_q <= LANE_ONE;
            wr_q   <= host_wr;
            wd_q   <= host_wdata;
        end
    end
endmodule

// File: rtl/bufptr_ram.sv
// Page store: PAGES pages of 2^OFF_W bytes, kept as rows of LANES bytes.
// Synchronous byte write or byte read per cycle. Read data is registered.
// Assumes PAGES is a power of two; contents are not reset.
module bufptr_ram
    import bufptr_pkg::*;
#(
    parameter  int PAGES  = 4,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  off,
    input  logic [7:0]        wbyte,
    output logic [7:0]        rbyte
);
    localparam int ROW_W = PAGE_W + OFF_W - LANE_W;
    localparam int ROWS  = 1 << ROW_W;

    logic [LANES-1:0][7:0] mem [ROWS];
    logic [ROW_W-1:0]      row;
    logic [LANE_W-1:0]     lane;

    assign row  = {page, off[OFF_W-1:LANE_W]};
    assign lane = off[LANE_W-1:0];

    // Write one byte lane, or read one byte lane into the output register.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[row][lane] <= wbyte;
        end else if (re) begin
            rbyte <= mem[row][lane];
        end
    end
endmodule

// File: rtl/bufptr_port.sv
// Buffer pointer port top: decodes host accesses and forms page and offset
// from the pointer. Drives the page store and assembles read data.
// Assumes pkt_page and rx_head hold steady during a word access.
module bufptr_port
    import bufptr_pkg::*;
#(
    parameter  int PAGES  = 4,
    localparam int PAGE_W = $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic              host_word,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    input  logic [PAGE_W-1:0] pkt_page,
    input  logic [PAGE_W-1:0] rx_head
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    logic              beat_v, beat_wr, beat_last, beat_word, ptr_acc;
    logic [LANE_W-1:0] beat_lane;
    logic [7:0]        beat_byte;
    logic [PTR_W-1:0]  ptr_q;
    logic              ld_lo, ld_hi, step;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic [7:0]        ram_q;
    logic              ptr_rd;
    logic              rd_pend_q;
    logic [LANE_W-1:0] rd_lane_q;
    logic [LANES-1:0][7:0] acc_q;
    logic [7:0]        ptr_rd_q;
    rsrc_e             src_q;

    bufptr_seq seq_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_word(host_word),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .beat_v(beat_v), .beat_wr(beat_wr), .beat_lane(beat_lane),
        .beat_byte(beat_byte), .beat_last(beat_last), .beat_word(beat_word),
        .ptr_acc(ptr_acc)
    );

    assign ld_lo  = ptr_acc && host_wr && (host_addr[1:0] == 2'd0);
    assign ld_hi  = ptr_acc && host_wr && (host_addr[1:0] == 2'd1);
    assign ptr_rd = ptr_acc && !host_wr;
    assign step   = beat_v && ptr_q[INC_BIT];

    bufptr_reg reg_i (
        .clk(clk), .rst_n(rst_n), .ld_lo(ld_lo), .ld_hi(ld_hi),
        .ld_byte(host_wdata[7:0]), .step(step), .ptr(ptr_q)
    );

    // Address generation: pick page source, add the lane unless stepping.
    always_comb begin
        page = ptr_q[SEL_BIT] ? rx_head : pkt_page;
        off  = ptr_q[OFF_W-1:0];
        if (!ptr_q[INC_BIT]) begin
            off = ptr_q[OFF_W-1:0] + OFF_W'(beat_lane);
        end
    end

    bufptr_ram #(.PAGES(PAGES)) ram_i (
        .clk(clk), .we(beat_v && beat_wr), .re(beat_v && !beat_wr),
        .page(page), .off(off), .wbyte(beat_byte), .rbyte(ram_q)
    );

    // Read return: track pending lanes, gather bytes, pulse valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rvalid <= 1'b0;
            rd_pend_q   <= 1'b0;
            rd_lane_q   <= '0;
            acc_q       <= '0;
            ptr_rd_q    <= '0;
            src_q       <= SRC_PTR;
        end else begin
            host_rvalid <= ptr_rd || (beat_v && !beat_wr && beat_last);
            rd_pend_q   <= beat_v && !beat_wr;
            rd_lane_q   <= beat_lane;
            if (rd_pend_q && rd_lane_q != LAST_LANE) begin
                acc_q[rd_lane_q] <= ram_q;
            end
            if (ptr_rd) begin
                src_q <= SRC_PTR;
                case (host_addr[1:0])
                    2'd0:    ptr_rd_q <= ptr_q[7:0];
                    2'd1:    ptr_rd_q <= ptr_q[PTR_W-1:8] & HI_MASK;
                    default: ptr_rd_q <= '0;
                endcase
            end else if (beat_v && !beat_wr && beat_last) begin
                src_q <= beat_word ? SRC_WORD : SRC_BYTE;
            end
        end
    end

    // Output mux for the returned data.
    always_comb begin
        case (src_q)
            SRC_PTR:  host_rdata = {24'd0, ptr_rd_q};
            SRC_BYTE: host_rdata = {24'd0, ram_q};
            default:  host_rdata = {ram_q, acc_q[LANES-2:0]};
        endcase
    end
endmodule

// File: rtl/bufptr_port_chk.sv
// Checker: timing and pointer-update properties of the buffer pointer port.
// Attached to every bufptr_port instance by the bind below.
module bufptr_port_chk
    import bufptr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_req,
    input logic             host_wr,
    input logic             host_word,
    input logic [2:0]       host_addr,
    input logic             host_ready,
    input logic             host_rvalid,
    input logic             rdata_b3,
    input logic [PTR_W-1:0] ptr,
    input logic             beat_v
);
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_wr && !(host_word && host_addr[2])) |=> host_rvalid); // R8
    AST_WR_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && host_wr && !host_word) |=> !host_rvalid); // R8
    AST_WORD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && host_word && host_addr[2]) |=> !host_ready); // R7
    AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_wr && host_addr == 3'd1) |=> !rdata_b3); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_v && ptr[INC_BIT]) |=>
        (ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + 1'b1)) &&
        (ptr[PTR_W-1:OFF_W] == $past(ptr[PTR_W-1:OFF_W]))); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_v && !ptr[INC_BIT]) |=> $stable(ptr)); // R5
endmodule

bind bufptr_port bufptr_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_word(host_word), .host_addr(host_addr), .host_ready(host_ready),
    .host_rvalid(host_rvalid), .rdata_b3(host_rdata[3]), .ptr(ptr_q),
    .beat_v(beat_v)
);

// File: tb/bufptr_port_tb_top.sv
// Directed bench for the buffer pointer port; one task per scenario.
module bufptr_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0, host_word = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [31:0] host_rdata;
    logic [1:0]  pkt_page = '0, rx_head = '0;
    int          vectors = 0, miscompares = 0;

    bufptr_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_word(host_word), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .pkt_page(pkt_page), .rx_head(rx_head)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic word, input logic [2:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd);
        int beats;
        beats = (word && addr[2]) ? 4 : 1;
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_word = word; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        for (int i = 1; i < beats; i++) begin
            chk(host_ready == 1'b0, "R7 ready low during word beats", 32'(host_ready), 32'd0);
            @(negedge clk);
        end
        chk(host_rvalid == !wr, "R8 return pulse after final beat", 32'(host_rvalid), 32'(!wr));
        rd = host_rdata;
    endtask

    task automatic set_ptr(input logic [15:0] v);
        logic [31:0] d;
        xfer(1'b1, 1'b0, 3'd0, {24'd0, v[7:0]}, d);
        xfer(1'b1, 1'b0, 3'd1, {24'd0, v[15:8]}, d);
    endtask

    task automatic rd8(input logic [2:0] addr, output logic [7:0] b);
        logic [31:0] d;
        xfer(1'b0, 1'b0, addr, 32'd0, d);
        b = d[7:0];
    endtask

    task automatic wr8(input logic [2:0] addr, input logic [7:0] b);
        logic [31:0] d;
        xfer(1'b1, 1'b0, addr, {24'd0, b}, d);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk(host_ready == 1'b1, "R1 ready after reset", 32'(host_ready), 32'd1);
        chk(host_rvalid == 1'b0, "R1 no return after reset", 32'(host_rvalid), 32'd0);
        rd8(3'd0, b); chk(b == 8'h00, "R1 pointer low after reset", 32'(b), 32'h00);
        rd8(3'd1, b); chk(b == 8'h00, "R1 pointer high after reset", 32'(b), 32'h00);
    endtask

    task automatic t_ptr_regs();
        logic [7:0] b;
        set_ptr(16'hFF34);
        rd8(3'd0, b); chk(b == 8'h34, "R2 pointer low readback", 32'(b), 32'h34);
        rd8(3'd1, b); chk(b == 8'hF7, "R3 pointer high masked", 32'(b), 32'hF7);
        wr8(3'd1, 8'h0A);
        rd8(3'd1, b); chk(b == 8'h02, "R3 bit 11 hidden", 32'(b), 32'h02);
        rd8(3'd0, b); chk(b == 8'h34, "R2 low kept by high write", 32'(b), 32'h34);
    endtask

    task automatic t_offset_mode();
        logic [7:0] b; logic [31:0] d;
        pkt_page = 2'd1;
        set_ptr(16'h0010);
        for (int k = 0; k < 4; k++) wr8(3'(4 + k), 8'(8'hA0 + k));
        rd8(3'd0, b); chk(b == 8'h10, "R5 pointer held in offset mode", 32'(b), 32'h10);
        xfer(1'b0, 1'b1, 3'd4, 32'd0, d);
        chk(d == 32'hA3A2A1A0, "R7 word read lane order", d, 32'hA3A2A1A0);
        rd8(3'd6, b); chk(b == 8'hA2, "R5 window index adds to offset", 32'(b), 32'hA2);
    endtask

    task automatic t_autoinc();
        logic [7:0] b; logic [31:0] d;
        pkt_page = 2'd2;
        set_ptr(16'h4020);
        xfer(1'b1, 1'b1, 3'd4, 32'h11223344, d);
        rd8(3'd0, b); chk(b == 8'h24, "R6 pointer stepped four times", 32'(b), 32'h24);
        rd8(3'd1, b); chk(b == 8'h40, "R6 control bits kept", 32'(b), 32'h40);
        set_ptr(16'h0020);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] e;
            e = 8'(32'h11223344 >> (8 * k));
            rd8(3'(4 + k), b); chk(b == e, "R7 word write byte placement", 32'(b), 32'(e));
        end
        set_ptr(16'h4021);
        rd8(3'd7, b); chk(b == 8'h33, "R6 window index ignored when stepping", 32'(b), 32'h33);
        rd8(3'd0, b); chk(b == 8'h22, "R6 step after read", 32'(b), 32'h22);
    endtask

    task automatic t_wrap();
        logic [7:0] b;
        pkt_page = 2'd2;
        set_ptr(16'h57FF);
        wr8(3'd4, 8'h5A);
        rd8(3'd0, b); chk(b == 8'h00, "R6 offset wraps to zero", 32'(b), 32'h00);
        rd8(3'd1, b); chk(b == 8'h50, "R6 wrap keeps bits 15:11", 32'(b), 32'h50);
        set_ptr(16'h07FF);
        rd8(3'd4, b); chk(b == 8'h5A, "R6 byte stored at 0x7FF", 32'(b), 32'h5A);
        set_ptr(16'h07FE);
        wr8(3'd7, 8'hC3);
        set_ptr(16'h0001);
        rd8(3'd4, b); chk(b == 8'hC3, "R5 offset sum wraps in page", 32'(b), 32'hC3);
    endtask

    task automatic t_page_sel();
        logic [7:0] b;
        rx_head = 2'd0;
        set_ptr(16'h0040);
        pkt_page = 2'd0; wr8(3'd4, 8'h01);
        pkt_page = 2'd3; wr8(3'd4, 8'h02);
        rx_head = 2'd3; pkt_page = 2'd0;
        set_ptr(16'h8040);
        rd8(3'd4, b); chk(b == 8'h02, "R4 bit 15 selects receive head", 32'(b), 32'h02);
        wr8(3'd4, 8'h77);
        set_ptr(16'h0040);
        rd8(3'd4, b); chk(b == 8'h01, "R10 other page untouched", 32'(b), 32'h01);
        pkt_page = 2'd3;
        rd8(3'd4, b); chk(b == 8'h77, "R4 bit 15 clear selects packet page", 32'(b), 32'h77);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] b; logic [31:0] d;
        pkt_page = 2'd1;
        set_ptr(16'h0100);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_word = 1'b1; host_addr = 3'd4;
        host_wdata = 32'hDEADBEEF;
        @(negedge clk);
        host_word = 1'b0; host_addr = 3'd0; host_wdata = 32'h000000EE;
        for (int i = 0; i < 3; i++) begin
            chk(host_ready == 1'b0, "R9 busy during word", 32'(host_ready), 32'd0);
            @(negedge clk);
        end
        host_req = 1'b0;
        rd8(3'd0, b); chk(b == 8'h00, "R9 request during busy ignored", 32'(b), 32'h00);
        xfer(1'b0, 1'b1, 3'd4, 32'd0, d);
        chk(d == 32'hDEADBEEF, "R7 word round trip", d, 32'hDEADBEEF);
        @(negedge clk);
        chk(host_rvalid == 1'b0, "R8 return lasts one cycle", 32'(host_rvalid), 32'd0);
    endtask

    task automatic t_ptr_word();
        logic [7:0] b; logic [31:0] d;
        xfer(1'b1, 1'b1, 3'd0, 32'h12345699, d);
        chk(host_ready == 1'b1, "R7 word flag ignored on pointer", 32'(host_ready), 32'd1);
        rd8(3'd0, b); chk(b == 8'h99, "R7 pointer takes one byte", 32'(b), 32'h99);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R1-wide run actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ptr_regs();
        t_offset_mode();
        t_autoinc();
        t_wrap();
        t_page_sel();
        t_busy_ignore();
        t_ptr_word();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule